// File: doc/BRIEF.md
# Retention Handshake Responder

This block answers a power controller that wants to put the processor domain into retention. The controller pulls an active-low request line, which is not related to the block clock. The block synchronises that line, decides once per request whether retention is safe, and returns exactly one answer. The answer is either an active-low accept or an active-high deny. The answer stays asserted until the controller withdraws the request. After the synchronised request has gone high again, the block clears the answer.

Retention is granted only when all of these hold: software has enabled the feature, neither clock-force override is set, and the core reports that it is idling in wait-for-interrupt standby. In every other case the request is denied. The block also drives a registered activity hint. The controller may use the hint to avoid asking when a deny is likely.

Top module: `retention_handshake`

## Requirements
- R1: While rstN is low, acceptN is 1, deny is 0 and activeHint is 1.
- R2: reqN passes through SYNC_STAGES flops before use. The answer to a falling reqN appears at the (SYNC_STAGES+1)th rising clock edge after the fall, and not earlier.
- R3: A request is accepted (acceptN goes to 0) when retEnable=1, forceClkA=0, forceClkB=0 and coreIdle=1 at the decision edge.
- R4: A request made while retEnable=0 is answered with deny=1.
- R5: A request made while forceClkA=1 or forceClkB=1 is answered with deny=1.
- R6: A request made while coreIdle=0 is answered with deny=1.
- R7: Each request gets exactly one answer. acceptN=0 and deny=1 never occur in the same cycle.
- R8: After an accept, acceptN stays 0 while reqN stays low. After reqN rises, acceptN returns to 1 at the (SYNC_STAGES+1)th rising edge.
- R9: After a deny, deny stays 1 while reqN stays low. After reqN rises, deny returns to 0 at the (SYNC_STAGES+1)th rising edge.
- R10: The decision is frozen once taken. A change to retEnable, forceClkA, forceClkB or coreIdle during a held answer does not change that answer.
- R11: activeHint is a register of (!coreIdle || wakePending) and follows the inputs one rising edge later.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 1 | Asynchronous active-low retention request |
| retEnable | input | 1 | Retention feature enable |
| forceClkA | input | 1 | First clock-force override; forces deny |
| forceClkB | input | 1 | Second clock-force override; forces deny |
| coreIdle | input | 1 | Core is in wait-for-interrupt standby |
| wakePending | input | 1 | A wake event is pending |
| acceptN | output | 1 | Active-low accept, registered |
| deny | output | 1 | Active-high deny, registered |
| activeHint | output | 1 | Advisory activity hint, registered |

## Verification
The bench times every answer to the exact edge. A design that samples reqN with too few flops answers early. A design with an extra pipeline stage answers late. Each deny cause is raised on its own. A design that combines the enable and the overrides wrongly would accept one of them. While an answer is held, the configuration is flipped to the opposite verdict. A design that re-evaluates the decision would then switch its answer or raise both outputs at once.

// File: rtl/retention_pkg.sv
package retention_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANTED = 2'd1,
    ST_REFUSED = 2'd2
  } rhState_t;

  typedef struct packed {
    logic setAccept;
    logic clrAccept;
    logic setDeny;
    logic clrDeny;
  } rhStrobes_t;

endpackage

// File: rtl/rh_sync.sv
module rh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[TOP];
endmodule

// File: rtl/rh_ctrl.sv
module rh_ctrl
  import retention_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       retEnable,
  input  logic       forceClkA,
  input  logic       forceClkB,
  input  logic       coreIdle,
  output rhStrobes_t strobes
);
  rhState_t state, nextState;
  logic     grantOk;

  assign grantOk = retEnable && !forceClkA && !forceClkB && coreIdle;

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (!reqSync) begin
          if (grantOk) begin
            strobes.setAccept = 1'b1;
            nextState         = ST_GRANTED;
          end else begin
            strobes.setDeny = 1'b1;
            nextState       = ST_REFUSED;
          end
        end
      end
      ST_GRANTED: begin
        if (reqSync) begin
          strobes.clrAccept = 1'b1;
          nextState         = ST_IDLE;
        end
      end
      ST_REFUSED: begin
        if (reqSync) begin
          strobes.clrDeny = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R7: at most one strobe per cycle, so one answer per request
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R10: a taken decision is held while the request stays low
  a_r10_granted_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRANTED && !reqSync) |=> (state == ST_GRANTED));
  a_r10_refused_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFUSED && !reqSync) |=> (state == ST_REFUSED));
endmodule

// File: rtl/rh_datapath.sv
module rh_datapath
  import retention_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rhStrobes_t strobes,
  input  logic       coreIdle,
  input  logic       wakePending,
  output logic       acceptN,
  output logic       deny,
  output logic       activeHint
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptN    <= 1'b1;
      deny       <= 1'b0;
      activeHint <= 1'b1;
    end else begin
      if (strobes.setAccept)      acceptN <= 1'b0;
      else if (strobes.clrAccept) acceptN <= 1'b1;
      if (strobes.setDeny)        deny    <= 1'b1;
      else if (strobes.clrDeny)   deny    <= 1'b0;
      activeHint <= !coreIdle || wakePending;
    end
  end

  // R7: the two answers are never active together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!acceptN && deny));

  // R11: the hint follows core activity one edge later
  a_r11_hint_high: assert property (@(posedge clk) disable iff (!rstN)
    (!coreIdle || wakePending) |=> activeHint);
  a_r11_hint_low: assert property (@(posedge clk) disable iff (!rstN)
    (coreIdle && !wakePending) |=> !activeHint);
endmodule

// File: rtl/retention_handshake.sv
module retention_handshake
  import retention_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  input  logic retEnable,
  input  logic forceClkA,
  input  logic forceClkB,
  input  logic coreIdle,
  input  logic wakePending,
  output logic acceptN,
  output logic deny,
  output logic activeHint
);
  logic       reqSync;
  rhStrobes_t strobes;

  rh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(reqN), .syncOut(reqSync)
  );

  rh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqSync(reqSync),
    .retEnable(retEnable), .forceClkA(forceClkA), .forceClkB(forceClkB),
    .coreIdle(coreIdle), .strobes(strobes)
  );

  rh_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .coreIdle(coreIdle), .wakePending(wakePending),
    .acceptN(acceptN), .deny(deny), .activeHint(activeHint)
  );

  // R3: an accept only follows an edge where every grant condition held
  a_r3_accept_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(acceptN) |-> $past(retEnable && !forceClkA && !forceClkB && coreIdle));

  // R4, R5, R6: a deny only follows an edge where a grant condition failed
  a_r6_deny_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deny) |-> !$past(retEnable && !forceClkA && !forceClkB && coreIdle));

  // R8: an accept is held while the synchronised request is low
  a_r8_accept_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!acceptN && !reqSync) |=> !acceptN);

  // R9: a deny is held while the synchronised request is low
  a_r9_deny_hold: assert property (@(posedge clk) disable iff (!rstN)
    (deny && !reqSync) |=> deny);
endmodule

// File: tb/tb_retention_handshake.sv
`timescale 1ns/100ps
module tb_retention_handshake;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN, reqN, retEnable, forceClkA, forceClkB, coreIdle, wakePending;
  logic acceptN, deny, activeHint;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  bit    expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  retention_handshake #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .retEnable(retEnable),
    .forceClkA(forceClkA), .forceClkB(forceClkB), .coreIdle(coreIdle),
    .wakePending(wakePending), .acceptN(acceptN), .deny(deny),
    .activeHint(activeHint)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected answer when a new one appears
  bit prevResp = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      bit resp;
      resp = (acceptN === 1'b0) || (deny === 1'b1);
      if ((acceptN === 1'b0) && (deny === 1'b1)) begin
        tests++; fails++;
        $display("FAIL R7: actual both answers expected one");
      end
      if (resp && !prevResp) begin
        if (expQ.size() == 0) begin
          tests++; fails++;
          $display("FAIL R7: actual unexpected answer expected none");
        end else begin
          bit    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checkEq({t, " answer is accept"}, int'(acceptN === 1'b0), int'(e));
        end
      end
      prevResp = resp;
    end else begin
      prevResp = 1'b0;
    end
  end

  // Driver: one full request, hold and release sequence
  task automatic runRequest(input bit en, input bit fa, input bit fb,
                            input bit idle, input bit flip, input string tag);
    bit exp;
    @(negedge clk);
    retEnable = en; forceClkA = fa; forceClkB = fb; coreIdle = idle;
    exp = en && !fa && !fb && idle;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    reqN = 1'b0;
    for (int i = 0; i < SYNC; i++) begin
      @(negedge clk);
      checkEq("R2 no early answer", int'(acceptN === 1'b0 || deny === 1'b1), 0);
    end
    @(negedge clk);
    checkEq("R2 answer on time", int'(acceptN === 1'b0 || deny === 1'b1), 1);
    if (flip) begin
      if (exp) retEnable = 1'b0;
      else begin retEnable = 1'b1; forceClkA = 1'b0; forceClkB = 1'b0; coreIdle = 1'b1; end
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (exp) checkEq(flip ? "R10 accept frozen" : "R8 accept held", int'(acceptN), 0);
      else     checkEq(flip ? "R10 deny frozen" : "R9 deny held", int'(deny), 1);
    end
    reqN = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(negedge clk);
      if (exp) checkEq("R8 accept held until sync", int'(acceptN), 0);
      else     checkEq("R9 deny held until sync", int'(deny), 1);
    end
    @(negedge clk);
    checkEq(exp ? "R8 accept released" : "R9 deny released", int'(acceptN), 1);
    checkEq(exp ? "R8 no deny" : "R9 deny cleared", int'(deny), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; reqN = 1'b1; retEnable = 1'b0; forceClkA = 1'b0;
    forceClkB = 1'b0; coreIdle = 1'b1; wakePending = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 reset acceptN", int'(acceptN), 1);
    checkEq("R1 reset deny", int'(deny), 0);
    checkEq("R1 reset activeHint", int'(activeHint), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runRequest(1, 0, 0, 1, 0, "R3 grant");
    runRequest(0, 0, 0, 1, 0, "R4 disabled");
    runRequest(1, 1, 0, 1, 0, "R5 force A");
    runRequest(1, 0, 1, 1, 0, "R5 force B");
    runRequest(1, 1, 1, 1, 0, "R5 both forces");
    runRequest(1, 0, 0, 0, 0, "R6 core busy");
    runRequest(1, 0, 0, 1, 1, "R10 grant then flip");
    runRequest(1, 1, 0, 0, 1, "R10 deny then flip");
    runRequest(1, 0, 0, 1, 0, "R3 grant again");

    @(negedge clk);
    coreIdle = 1'b1; wakePending = 1'b0;
    @(negedge clk);
    checkEq("R11 hint low when idle", int'(activeHint), 0);
    wakePending = 1'b1;
    @(negedge clk);
    checkEq("R11 hint high on wake", int'(activeHint), 1);
    wakePending = 1'b0; coreIdle = 1'b0;
    @(negedge clk);
    checkEq("R11 hint high when busy", int'(activeHint), 1);
    coreIdle = 1'b1;
    @(negedge clk);
    checkEq("R11 hint falls again", int'(activeHint), 0);

    repeat (3) @(negedge clk);
    checkEq("R7 all answers seen", expQ.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule